// File: doc/BRIEF.md
# Glitch-Free System Clock Source Selector

This block chooses which of four clock sources drives the system clock: a fast RC oscillator, a slow RC oscillator, an external crystal or clock input, and a PLL output. Software, or a configuration register upstream, presents a 2-bit source request with a one-cycle valid strobe, together with the crystal configuration field and the PLL enable bit. The selector decides whether the request is legal at that moment. If it is, the selector moves the output clock to the new source without producing any short pulse.

Each source has its own gate, and every gate opens and closes only while its own clock is low. A gate is driven from an enable that has been synchronised into that clock's domain. During a handover the old gate is always closed and confirmed closed before the new gate is asked to open. Leaving the PLL uses this same break-before-make sequence, so the PLL clock is never cut mid-pulse. Crystal and PLL readiness is tracked by stabilisation counters clocked by the fast RC source. Their counts are parameters, so simulation can use short values.

Top module: `clk_source_switch`

## Requirements
- R1: While reset is held and right after it, `cur_src_o` is 0 (fast RC), `busy_o` and `err_o` are 0, and the output clock runs at the fast RC period.
- R2: A request for code 0 (fast RC) or code 1 (slow RC) is always accepted, whatever the crystal field and PLL enable hold.
- R3: A request for code 2 (external input) is accepted only if `xtal_cfg_i` is non-zero and has stayed non-zero for at least `XI_WAIT_CYC` fast RC cycles. Otherwise it is rejected.
- R4: A request for code 3 (PLL) is accepted only if `xtal_cfg_i` is non-zero and `pll_en_i` is 1, and both have held together for at least `PLL_WAIT_CYC` fast RC cycles. Otherwise it is rejected.
- R5: A rejected request sets `err_o` one cycle later. It leaves `cur_src_o` and the output clock unchanged and never raises `busy_o`. The next accepted request clears `err_o`.
- R6: At most one source gate is open at any time. Every high pulse of the output clock is a full high phase of one source clock, and every low gap is at least the shortest source half period.
- R7: `busy_o` rises the cycle after a request for a different source is accepted. It stays high until the new source drives the output clock. `cur_src_o` shows the old code while busy and the new code from the cycle `busy_o` falls.
- R8: A request presented while `busy_o` is high is ignored: `err_o` does not change and the handover finishes on the originally accepted source.
- R9: A legal request for the source already selected clears `err_o` and does not raise `busy_o`.
- R10: Switching away from the PLL follows the same break-before-make sequence, and the output then runs at the new source's period with no shortened pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rcfast_i | input | 1 | Fast RC clock; also clocks the control logic and the timers |
| clk_rcslow_i | input | 1 | Slow RC clock |
| clk_xi_i | input | 1 | External crystal or clock input |
| clk_pll_i | input | 1 | PLL output clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | One-cycle strobe that presents a source request |
| req_src_i | input | 2 | Requested source: 0 fast RC, 1 slow RC, 2 external, 3 PLL |
| xtal_cfg_i | input | XCFG_W | Crystal configuration; non-zero means the crystal is enabled |
| pll_en_i | input | 1 | PLL enable |
| clk_sys_o | output | 1 | Selected system clock |
| cur_src_o | output | 2 | Code of the source now driving `clk_sys_o` |
| busy_o | output | 1 | Handover in progress |
| err_o | output | 1 | Last evaluated request was rejected |

## Verification
Accept and reject decisions become visible one fast RC cycle after the strobe edge. The bench's reference model therefore applies each request at the same rising edge the design samples it, and compares `err_o`, `busy_o` and `cur_src_o` at the following falling edge, on every cycle. A handover takes a variable number of cycles, because the old and new clocks each have their own synchroniser depth and phase. The model does not predict when `busy_o` falls. Instead it requires `cur_src_o` to match the old code while busy and the new code once `busy_o` drops, and a bounded wait flags a handover that never completes. Output clock shape is checked continuously by measuring every high and low pulse of `clk_sys_o`. After each handover the next full period is compared with the chosen source's period.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
   localparam int unsigned NUM_SRC = 4;

   typedef enum logic [1:0] {
      SRC_RCFAST = 2'b00,
      SRC_RCSLOW = 2'b01,
      SRC_XI     = 2'b10,
      SRC_PLL    = 2'b11
   } src_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_DROP  = 2'b01,
      ST_RAISE = 2'b10
   } hand_st_e;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("clksw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
      else         sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/clksw_stab_timer.sv
`timescale 1ns/1ps
module clksw_stab_timer #(
   parameter int unsigned WAIT_CYC = 100000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   output logic ready_o
);
   localparam int unsigned CW = $clog2(WAIT_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);

   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("clksw_stab_timer: WAIT_CYC must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!arm_i)          cnt_q <= '0;
      else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
   end

   assign ready_o = (cnt_q == LIMIT);

   AST_READY_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> $past(arm_i)); // R3
   AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LIMIT); // R4
endmodule

// File: rtl/clksw_gate_cell.sv
`timescale 1ns/1ps
module clksw_gate_cell #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RESET_ON    = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic gate_o,
   output logic clk_o
);
   logic en_sync;
   logic gate_q;

   clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RESET_ON)) u_en_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (en_i),
      .q_o    (en_sync)
   );

   // gate changes only on the falling edge, i.e. while the source is low
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gate_q <= RESET_ON;
      else         gate_q <= en_sync;
   end

   assign gate_o = gate_q;
   assign clk_o  = clk_i & gate_q;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
   import clksw_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic [1:0]         req_src_i,
   input  logic               xtal_on_i,
   input  logic               pll_en_i,
   input  logic               xi_ready_i,
   input  logic               pll_ready_i,
   input  logic [NUM_SRC-1:0] gate_i,
   output logic [NUM_SRC-1:0] en_o,
   output logic [1:0]         cur_o,
   output logic               busy_o,
   output logic               err_o
);
   logic [NUM_SRC-1:0] ack;
   hand_st_e           st_q;
   src_e               cur_q, tgt_q, req_src;
   logic [NUM_SRC-1:0] en_q;
   logic               err_q, req_ok;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_ack
      clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(i == 0)) u_ack_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (gate_i[i]),
         .q_o    (ack[i])
      );
   end

   assign req_src = src_e'(req_src_i);

   always_comb begin
      unique case (req_src)
         SRC_RCFAST, SRC_RCSLOW: req_ok = 1'b1;
         SRC_XI:                 req_ok = xtal_on_i & xi_ready_i;
         default:                req_ok = xtal_on_i & pll_en_i & pll_ready_i;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         cur_q <= SRC_RCFAST;
         tgt_q <= SRC_RCFAST;
         en_q  <= NUM_SRC'(1);
         err_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  if (!req_ok) begin
                     err_q <= 1'b1;
                  end else begin
                     err_q <= 1'b0;
                     if (req_src != cur_q) begin
                        tgt_q <= req_src;
                        en_q  <= '0;
                        st_q  <= ST_DROP;
                     end
                  end
               end
            end
            ST_DROP: begin
               if (!ack[cur_q]) begin
                  en_q <= NUM_SRC'(1) << tgt_q;
                  st_q <= ST_RAISE;
               end
            end
            ST_RAISE: begin
               if (ack[tgt_q]) begin
                  cur_q <= tgt_q;
                  st_q  <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign en_o   = en_q;
   assign cur_o  = cur_q;
   assign busy_o = (st_q != ST_IDLE);
   assign err_o  = err_q;

   AST_REJECT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && req_valid_i && !req_ok) |=> (err_o && !busy_o && $stable(cur_o))); // R5
   AST_BUSY_ON_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && req_valid_i && req_ok && req_src != cur_q) |=> busy_o); // R7
   AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> ($stable(err_o) && $stable(tgt_q))); // R8
   AST_SAME_SRC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && req_valid_i && req_ok && req_src == cur_q) |=> (!busy_o && !err_o)); // R9
   AST_DONE_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RAISE && ack[tgt_q]) |=> (!busy_o && cur_o == $past(tgt_q))); // R7
endmodule

// File: rtl/clk_source_switch.sv
`timescale 1ns/1ps
module clk_source_switch
   import clksw_pkg::*;
#(
   parameter int unsigned XCFG_W       = 2,
   parameter int unsigned XI_WAIT_CYC  = 100000,
   parameter int unsigned PLL_WAIT_CYC = 200000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic              clk_rcfast_i,
   input  logic              clk_rcslow_i,
   input  logic              clk_xi_i,
   input  logic              clk_pll_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic [1:0]        req_src_i,
   input  logic [XCFG_W-1:0] xtal_cfg_i,
   input  logic              pll_en_i,
   output logic              clk_sys_o,
   output logic [1:0]        cur_src_o,
   output logic              busy_o,
   output logic              err_o
);
   if (XCFG_W < 1) begin : g_bad_cfg
      $error("clk_source_switch: XCFG_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clk_source_switch: SYNC_STAGES must be at least 2");
   end

   logic [NUM_SRC-1:0] src_clk, gated_clk, gate_vec, en_vec;
   logic               xtal_on, pll_arm, xi_ready, pll_ready;

   assign src_clk = {clk_pll_i, clk_xi_i, clk_rcslow_i, clk_rcfast_i};
   assign xtal_on = |xtal_cfg_i;
   assign pll_arm = xtal_on & pll_en_i;

   clksw_stab_timer #(.WAIT_CYC(XI_WAIT_CYC)) u_xi_timer (
      .clk_i   (clk_rcfast_i),
      .rst_ni  (rst_ni),
      .arm_i   (xtal_on),
      .ready_o (xi_ready)
   );

   clksw_stab_timer #(.WAIT_CYC(PLL_WAIT_CYC)) u_pll_timer (
      .clk_i   (clk_rcfast_i),
      .rst_ni  (rst_ni),
      .arm_i   (pll_arm),
      .ready_o (pll_ready)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
      clksw_gate_cell #(.SYNC_STAGES(SYNC_STAGES), .RESET_ON(i == 0)) u_cell (
         .clk_i  (src_clk[i]),
         .rst_ni (rst_ni),
         .en_i   (en_vec[i]),
         .gate_o (gate_vec[i]),
         .clk_o  (gated_clk[i])
      );
   end

   clksw_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
      .clk_i       (clk_rcfast_i),
      .rst_ni      (rst_ni),
      .req_valid_i (req_valid_i),
      .req_src_i   (req_src_i),
      .xtal_on_i   (xtal_on),
      .pll_en_i    (pll_en_i),
      .xi_ready_i  (xi_ready),
      .pll_ready_i (pll_ready),
      .gate_i      (gate_vec),
      .en_o        (en_vec),
      .cur_o       (cur_src_o),
      .busy_o      (busy_o),
      .err_o       (err_o)
   );

   assign clk_sys_o = |gated_clk;

   AST_ONE_GATE_OPEN: assert property (@(posedge clk_rcfast_i) disable iff (!rst_ni)
      $onehot0(gate_vec)); // R6
   AST_ENABLE_ONEHOT0: assert property (@(posedge clk_rcfast_i) disable iff (!rst_ni)
      $onehot0(en_vec)); // R6
endmodule

// File: tb/tb_clk_source_switch.sv
`timescale 1ns/1ps
module tb_clk_source_switch;
   localparam int XI_W  = 20;
   localparam int PLL_W = 40;

   logic       clk = 1'b0, clk_slow = 1'b0, clk_xi = 1'b0, clk_pll = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_src = 2'd0;
   logic [1:0] xtal_cfg = 2'd0;
   logic       pll_en = 1'b0;
   logic       clk_sys, busy, err;
   logic [1:0] cur;

   always #5  clk      = ~clk;
   always #40 clk_slow = ~clk_slow;
   always #7  clk_xi   = ~clk_xi;
   always #2  clk_pll  = ~clk_pll;

   clk_source_switch #(.XCFG_W(2), .XI_WAIT_CYC(XI_W), .PLL_WAIT_CYC(PLL_W), .SYNC_STAGES(2)) dut (
      .clk_rcfast_i (clk),
      .clk_rcslow_i (clk_slow),
      .clk_xi_i     (clk_xi),
      .clk_pll_i    (clk_pll),
      .rst_ni       (rst_n),
      .req_valid_i  (req_valid),
      .req_src_i    (req_src),
      .xtal_cfg_i   (xtal_cfg),
      .pll_en_i     (pll_en),
      .clk_sys_o    (clk_sys),
      .cur_src_o    (cur),
      .busy_o       (busy),
      .err_o        (err)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic check(bit ok, string tag, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int m_xi = 0, m_pll = 0;
   int m_cur = 0, m_old = 0;
   bit e_err = 1'b0, m_acc = 1'b0, m_same = 1'b0, busy_seen = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_xi = 0; m_pll = 0; m_cur = 0; m_old = 0;
         e_err = 1'b0; m_acc = 1'b0; m_same = 1'b0;
      end else begin
         bit legal;
         m_acc = 1'b0; m_same = 1'b0;
         case (req_src)
            2'd0, 2'd1: legal = 1'b1;
            2'd2:       legal = (xtal_cfg != 0) && (m_xi >= XI_W);
            default:    legal = (xtal_cfg != 0) && pll_en && (m_pll >= PLL_W);
         endcase
         if (req_valid && !busy_seen) begin
            if (!legal) e_err = 1'b1;
            else begin
               e_err = 1'b0;
               if (int'(req_src) != m_cur) begin
                  m_old = m_cur; m_cur = int'(req_src); m_acc = 1'b1;
               end else m_same = 1'b1;
            end
         end
         if (xtal_cfg != 0) m_xi = (m_xi < XI_W) ? m_xi + 1 : m_xi; else m_xi = 0;
         if (xtal_cfg != 0 && pll_en) m_pll = (m_pll < PLL_W) ? m_pll + 1 : m_pll; else m_pll = 0;
      end
   end

   bit chk_on = 1'b0;
   always @(negedge clk) begin
      if (chk_on) begin
         if (!rst_n) begin
            check(cur == 2'd0, "R1 cur_src in reset", int'(cur), 0);
            check(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
            check(err == 1'b0, "R1 err in reset", int'(err), 0);
         end else begin
            check(err == e_err, "R5 err flag", int'(err), int'(e_err));
            check(int'(cur) == (busy ? m_old : m_cur), "R7 cur_src", int'(cur), busy ? m_old : m_cur);
            if (m_acc)  check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
            if (m_same) check(busy == 1'b0, "R9 no busy for same source", int'(busy), 0);
         end
      end
      busy_seen = busy;
   end

   // output clock pulse monitor (R6)
   realtime t_rise = 0.0, t_fall = 0.0;
   int bad_pulse = 0;
   function automatic bit near(realtime a, realtime b);
      return (a > b - 0.01) && (a < b + 0.01);
   endfunction
   always @(posedge clk_sys) begin
      t_rise = $realtime;
      if (t_fall > 0.0 && (t_rise - t_fall) < 1.99) bad_pulse++;
   end
   always @(negedge clk_sys) begin
      realtime w;
      t_fall = $realtime;
      w = t_fall - t_rise;
      if (!(near(w, 2.0) || near(w, 5.0) || near(w, 7.0) || near(w, 40.0))) bad_pulse++;
   end

   task automatic pulses_ok(string tag);
      check(bad_pulse == 0, tag, bad_pulse, 0);
      bad_pulse = 0;
   endtask

   task automatic period_is(realtime exp, string tag);
      realtime t0;
      @(posedge clk_sys); t0 = $realtime;
      @(posedge clk_sys);
      check(near($realtime - t0, exp), tag, int'(($realtime - t0) * 1000.0), int'(exp * 1000.0));
   endtask

   task automatic request(logic [1:0] s);
      @(negedge clk);
      req_valid = 1'b1; req_src = s;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle(string tag);
      int n = 0;
      while (busy && n < 500) begin @(negedge clk); n++; end
      check(!busy, tag, int'(busy), 0);
   endtask

   task automatic idle_cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #1ms;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 1 expected 0 (run hung)");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      chk_on = 1'b1;
      repeat (20) @(negedge clk);
      rst_n = 1'b1;
      idle_cycles(3);
      period_is(10.0, "R1 fast RC period after reset");

      // R3: no crystal configured
      request(2'd2);
      check(err == 1'b1 && cur == 2'd0, "R3 external rejected without crystal", int'(err), 1);
      // R9: same source clears error without handover
      request(2'd0);
      check(err == 1'b0 && busy == 1'b0, "R9 same-source request", int'(err), 0);

      // R3: crystal enabled but not yet stable
      @(negedge clk); xtal_cfg = 2'd1;
      idle_cycles(5);
      request(2'd2);
      check(err == 1'b1 && cur == 2'd0, "R3 external rejected before wait", int'(cur), 0);
      period_is(10.0, "R5 clock unchanged after reject");
      idle_cycles(XI_W);
      request(2'd2);
      check(busy == 1'b1, "R7 busy during external handover", int'(busy), 1);
      wait_idle("R7 external handover completes");
      check(cur == 2'd2, "R3 external selected", int'(cur), 2);
      period_is(14.0, "R3 external period");
      pulses_ok("R6 pulses fast to external");

      // R4: PLL not enabled, then enabled but not stable
      request(2'd3);
      check(err == 1'b1 && cur == 2'd2, "R4 PLL rejected when disabled", int'(err), 1);
      @(negedge clk); pll_en = 1'b1;
      idle_cycles(10);
      request(2'd3);
      check(err == 1'b1, "R4 PLL rejected before wait", int'(err), 1);
      idle_cycles(PLL_W);
      request(2'd3);
      // R8: request during the handover is ignored
      request(2'd1);
      check(busy == 1'b1 && err == 1'b0, "R8 request while busy ignored", int'(err), 0);
      wait_idle("R7 PLL handover completes");
      check(cur == 2'd3, "R8 handover ends on accepted PLL", int'(cur), 3);
      period_is(4.0, "R4 PLL period");
      pulses_ok("R6 pulses external to PLL");

      // R10: leave the PLL
      request(2'd0);
      wait_idle("R10 exit from PLL completes");
      check(cur == 2'd0, "R10 fast RC after PLL", int'(cur), 0);
      period_is(10.0, "R10 fast RC period after PLL");
      pulses_ok("R10 pulses leaving PLL");

      // R2: RC sources need no configuration
      @(negedge clk); xtal_cfg = 2'd0; pll_en = 1'b0;
      request(2'd1);
      check(err == 1'b0 && busy == 1'b1, "R2 slow RC accepted unconfigured", int'(busy), 1);
      wait_idle("R2 slow handover completes");
      check(cur == 2'd1, "R2 slow RC selected", int'(cur), 1);
      period_is(80.0, "R2 slow RC period");
      request(2'd0);
      wait_idle("R2 back to fast completes");
      check(cur == 2'd0, "R2 fast RC selected", int'(cur), 0);
      period_is(10.0, "R2 fast RC period");
      pulses_ok("R6 pulses slow RC round trip");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule